// File: doc/BRIEF.md
# Two-Register Stack Machine Core

This block is a single-cycle processor whose only operands are the two uppermost entries of a hardware stack, called top and next. Each clock it fetches one 16-bit instruction word from an internal word memory, executes it and updates the program counter. Instructions push small signed constants, move words between the stack and memory at a direct or stack-supplied address, branch on the value of top, and move the program counter to and from the stack so that a program can call and return. Arithmetic, bitwise, logical and comparison operators combine next with top, and a few stack-shuffle operations reorder the two.

Memory holds both code and 18-bit data. A plain write port fills it while reset is held. Eight I/O ports are addressed by the in and out instructions. Ports 0 to 3 reach the block's pins. An out to one of these updates a held output register and raises a one-cycle strobe for that port. This strobe acts as a valid with no ready: the consumer must take the word in that cycle, and the core never stalls on output. Ports 4 to 7 are internal latches that an in instruction can read back.

Top module: `tos_cpu`

## Requirements
- R1: While rst_n is low, the core holds the program counter at 0 and the stack empty with top and next at 0. It drives all external output registers to 0 and all strobes low. The first instruction executed after release is the one at address 0.
- R2: Opcode 1 pushes its low 12 bits, sign-extended to 18 bits. For example 0xFFD pushes 0x3FFFD and 0x800 pushes 0x3F800.
- R3: Opcode 2 pushes memory[A], where A is the low 12 bits. Opcode 3 writes top to memory[A] and pops it.
- R4: Misc sub-code 4 replaces top with memory[top]. Misc sub-code 5 writes top to memory[next] and pops both entries.
- R5: Opcode 4 jumps to A. Opcode 5 jumps to A if top is 0, and opcode 6 jumps to A if top is not 0. Both conditional jumps pop top whether or not the branch is taken.
- R6: Misc sub-code 6 pushes the address of the following instruction. Misc sub-code 7 pops top into the program counter.
- R7: Opcode 7 applies the ALU sub-code in bits 4:0. A binary sub-code replaces next and top with a single result. Sub-codes 0 to 3 are next+top, next-top, the low 18 bits of the signed product, and the signed product shifted arithmetically right by 8.
- R8: ALU sub-codes 4 to 11 are: shift left, logical shift right, and arithmetic shift right of next by top[4:0]; and, or, xor; logical and; logical or. Logical results are 1 or 0.
- R9: ALU sub-codes 12 to 17 compare next with top as signed values for ==, !=, >=, <=, > and <. Each gives 1 for true and 0 for false.
- R10: ALU sub-codes 18 to 20 replace top alone with its negation, its bitwise inverse, or its logical inverse (1 when top is 0, else 0).
- R11: Opcode 8 sub-codes 0 to 3 are dup (push top), drop (pop top), over (push next) and nip (remove next, keep top). The stack holds 16 values without loss.
- R12: Opcode 9 pushes port n and opcode 10 pops top to port n, where n is bits 2:0. Ports 0-3 read ext_in and write ext_out, and a write pulses that port's strobe for one cycle. Ports 4-7 are internal latches, reset to 0, and writing them raises no strobe.
- R13: Opcode 0 and opcodes 11 to 15 change nothing except advancing the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also enables memory loading |
| prog_we | input | 1 | Memory load strobe, used only while rst_n is low |
| prog_addr | input | 9 | Memory load word address |
| prog_data | input | 18 | Memory load word |
| ext_in | input | 72 | External input ports 0-3, port k in bits 18k+17:18k |
| ext_out | output | 72 | Held external output ports 0-3, same packing |
| ext_out_stb | output | 4 | One-cycle write strobe per external output port |

## Verification
The hardest state to reach from the pins is a completely full stack: all 16 values are live and the spill storage below next has wrapped its pointer. A program pushes sixteen constants and then folds them with fifteen additions, so any lost or misordered entry shows in the sum. Conditional branches are placed so that each taken and untaken path either emits or skips a port write. A sentinel left beneath them then exposes whether every branch popped top. Subroutine return is checked by pushing the program counter, adjusting it on the stack and popping it back, with the return path emitting a word.

// File: rtl/tos_pkg.sv
package tos_pkg;
  localparam int INSN_W = 16;
  localparam int FLD_W  = 12;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_PUSHI = 4'd1;
  localparam logic [3:0] OP_LOAD  = 4'd2;
  localparam logic [3:0] OP_STORE = 4'd3;
  localparam logic [3:0] OP_JMP   = 4'd4;
  localparam logic [3:0] OP_JZ    = 4'd5;
  localparam logic [3:0] OP_JNZ   = 4'd6;
  localparam logic [3:0] OP_ALU   = 4'd7;
  localparam logic [3:0] OP_MISC  = 4'd8;
  localparam logic [3:0] OP_IN    = 4'd9;
  localparam logic [3:0] OP_OUT   = 4'd10;

  localparam logic [2:0] M_DUP    = 3'd0;
  localparam logic [2:0] M_DROP   = 3'd1;
  localparam logic [2:0] M_OVER   = 3'd2;
  localparam logic [2:0] M_NIP    = 3'd3;
  localparam logic [2:0] M_LDI    = 3'd4;
  localparam logic [2:0] M_STI    = 3'd5;
  localparam logic [2:0] M_PUSHPC = 3'd6;
  localparam logic [2:0] M_POPPC  = 3'd7;

  typedef enum logic [1:0] {SC_KEEP, SC_PUSH, SC_POP, SC_POP2} stk_cmd_e;
  typedef enum logic [1:0] {AK_BIN, AK_UN, AK_NONE} alu_kind_e;
endpackage

// File: rtl/tos_mem.sv
module tos_mem #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] iaddr,
  output logic [DW-1:0] idata,
  input  logic [AW-1:0] daddr,
  output logic [DW-1:0] ddata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign idata = cells[iaddr];
  assign ddata = cells[daddr];
endmodule

// File: rtl/tos_stack.sv
module tos_stack
  import tos_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_cmd_e      cmd,
  input  logic [DW-1:0] new_top,
  output logic [DW-1:0] top_o,
  output logic [DW-1:0] next_o
);
  localparam int RD = DEPTH - 2;
  localparam int PW = (RD > 1) ? $clog2(RD) : 1;

  logic [DW-1:0] spill [RD];
  logic [PW-1:0] sp_q;
  logic [DW-1:0] top_q, next_q;

  function automatic logic [PW-1:0] up(input logic [PW-1:0] p);
    return (p == PW'(RD - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] dn(input logic [PW-1:0] p);
    return (p == '0) ? PW'(RD - 1) : p - PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q  <= '0;
      next_q <= '0;
      sp_q   <= '0;
    end else begin
      unique case (cmd)
        SC_PUSH: begin
          next_q <= top_q;
          top_q  <= new_top;
          sp_q   <= up(sp_q);
        end
        SC_POP: begin
          top_q  <= new_top;
          next_q <= spill[dn(sp_q)];
          sp_q   <= dn(sp_q);
        end
        SC_POP2: begin
          top_q  <= spill[dn(sp_q)];
          next_q <= spill[dn(dn(sp_q))];
          sp_q   <= dn(dn(sp_q));
        end
        default: top_q <= new_top;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && cmd == SC_PUSH) spill[sp_q] <= next_q;
  end

  assign top_o  = top_q;
  assign next_o = next_q;

  // R11
  push_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == SC_PUSH |=> (next_o == $past(top_o)) && (top_o == $past(new_top)));

  // R11
  pop_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == SC_POP |=> top_o == $past(new_top));
endmodule

// File: rtl/tos_alu.sv
module tos_alu
  import tos_pkg::*;
#(
  parameter int DW   = 18,
  parameter int FRAC = 8
) (
  input  logic [DW-1:0] nxt_i,
  input  logic [DW-1:0] top_i,
  input  logic [4:0]    op_i,
  output logic [DW-1:0] res_o,
  output alu_kind_e     kind_o
);
  localparam int SHW = $clog2(DW);

  logic signed [DW-1:0]   sa, sb;
  logic signed [2*DW-1:0] prod, fprod;
  logic [SHW-1:0]         sh;

  assign sa    = $signed(nxt_i);
  assign sb    = $signed(top_i);
  assign prod  = sa * sb;
  assign fprod = prod >>> FRAC;
  assign sh    = top_i[SHW-1:0];

  function automatic logic [DW-1:0] flag(input logic c);
    return {{(DW-1){1'b0}}, c};
  endfunction

  always_comb begin
    res_o  = top_i;
    kind_o = AK_BIN;
    case (op_i)
      5'd0:  res_o = nxt_i + top_i;
      5'd1:  res_o = nxt_i - top_i;
      5'd2:  res_o = prod[DW-1:0];
      5'd3:  res_o = fprod[DW-1:0];
      5'd4:  res_o = nxt_i << sh;
      5'd5:  res_o = nxt_i >> sh;
      5'd6:  res_o = sa >>> sh;
      5'd7:  res_o = nxt_i & top_i;
      5'd8:  res_o = nxt_i | top_i;
      5'd9:  res_o = nxt_i ^ top_i;
      5'd10: res_o = flag((nxt_i != '0) && (top_i != '0));
      5'd11: res_o = flag((nxt_i != '0) || (top_i != '0));
      5'd12: res_o = flag(sa == sb);
      5'd13: res_o = flag(sa != sb);
      5'd14: res_o = flag(sa >= sb);
      5'd15: res_o = flag(sa <= sb);
      5'd16: res_o = flag(sa > sb);
      5'd17: res_o = flag(sa < sb);
      5'd18: begin res_o = -top_i;            kind_o = AK_UN; end
      5'd19: begin res_o = ~top_i;            kind_o = AK_UN; end
      5'd20: begin res_o = flag(top_i == '0); kind_o = AK_UN; end
      default: kind_o = AK_NONE;
    endcase
  end
endmodule

// File: rtl/tos_ports.sv
module tos_ports #(
  parameter int DW    = 18,
  parameter int NPORT = 8,
  parameter int NEXT  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [$clog2(NPORT)-1:0] idx,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [NEXT*DW-1:0]    ext_in,
  output logic [NEXT*DW-1:0]    ext_out,
  output logic [NEXT-1:0]       ext_stb
);
  localparam int IW = $clog2(NPORT);

  logic [DW-1:0] port_q [NPORT];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NPORT; k++) begin
      if (!rst_n)                          port_q[k] <= '0;
      else if (we && idx == IW'(k))        port_q[k] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NEXT; k++) begin
      ext_stb[k] <= rst_n && we && (idx == IW'(k));
    end
  end

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    assign ext_out[g*DW +: DW] = port_q[g];
  end

  assign rdata = (idx < IW'(NEXT)) ? ext_in[idx*DW +: DW] : port_q[idx];

  // R12
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_stb));

  // R12
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && idx < IW'(NEXT)) |=> $stable(ext_out) && (ext_stb == '0));
endmodule

// File: rtl/tos_cpu.sv
module tos_cpu
  import tos_pkg::*;
#(
  parameter int DW    = 18,
  parameter int AW    = 9,
  parameter int DEPTH = 16,
  parameter int FRAC  = 8,
  parameter int NPORT = 8,
  parameter int NEXT  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [DW-1:0]      prog_data,
  input  logic [NEXT*DW-1:0] ext_in,
  output logic [NEXT*DW-1:0] ext_out,
  output logic [NEXT-1:0]    ext_out_stb
);
  localparam int IW = $clog2(NPORT);

  logic [AW-1:0]     pc_q, pc_nxt, pc_inc;
  logic [DW-1:0]     iword, rd_data, top, nxt, alu_res, io_rd, ntop;
  logic [3:0]        opc;
  logic [FLD_W-1:0]  fld;
  logic [AW-1:0]     tgt, daddr, st_addr;
  logic              st_we, io_we, mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DW-1:0]     mem_wdata;
  stk_cmd_e          scmd;
  alu_kind_e         akind;
  logic              unused_hi;

  assign opc       = iword[INSN_W-1 -: 4];
  assign fld       = iword[FLD_W-1:0];
  assign unused_hi = ^iword[DW-1:INSN_W];
  assign tgt       = fld[AW-1:0];
  assign pc_inc    = pc_q + AW'(1);
  assign daddr     = (opc == OP_LOAD) ? tgt : top[AW-1:0];

  assign mem_we    = rst_n ? st_we : prog_we;
  assign mem_waddr = rst_n ? st_addr : prog_addr;
  assign mem_wdata = rst_n ? top : prog_data;

  tos_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .iaddr(pc_q), .idata(iword), .daddr(daddr), .ddata(rd_data)
  );

  tos_stack #(.DW(DW), .DEPTH(DEPTH)) stk_i (
    .clk(clk), .rst_n(rst_n), .cmd(scmd), .new_top(ntop),
    .top_o(top), .next_o(nxt)
  );

  tos_alu #(.DW(DW), .FRAC(FRAC)) alu_i (
    .nxt_i(nxt), .top_i(top), .op_i(fld[4:0]), .res_o(alu_res), .kind_o(akind)
  );

  tos_ports #(.DW(DW), .NPORT(NPORT), .NEXT(NEXT)) io_i (
    .clk(clk), .rst_n(rst_n), .we(io_we), .idx(fld[IW-1:0]), .wdata(top),
    .rdata(io_rd), .ext_in(ext_in), .ext_out(ext_out), .ext_stb(ext_out_stb)
  );

  always_comb begin
    scmd    = SC_KEEP;
    ntop    = top;
    pc_nxt  = pc_inc;
    st_we   = 1'b0;
    st_addr = tgt;
    io_we   = 1'b0;
    case (opc)
      OP_PUSHI: begin scmd = SC_PUSH; ntop = {{(DW-FLD_W){fld[FLD_W-1]}}, fld}; end
      OP_LOAD:  begin scmd = SC_PUSH; ntop = rd_data; end
      OP_STORE: begin scmd = SC_POP;  ntop = nxt; st_we = 1'b1; end
      OP_JMP:   pc_nxt = tgt;
      OP_JZ:    begin scmd = SC_POP; ntop = nxt; if (top == '0) pc_nxt = tgt; end
      OP_JNZ:   begin scmd = SC_POP; ntop = nxt; if (top != '0) pc_nxt = tgt; end
      OP_ALU: begin
        if (akind == AK_BIN)     begin scmd = SC_POP; ntop = alu_res; end
        else if (akind == AK_UN) ntop = alu_res;
      end
      OP_MISC: begin
        case (fld[2:0])
          M_DUP:    scmd = SC_PUSH;
          M_DROP:   begin scmd = SC_POP; ntop = nxt; end
          M_OVER:   begin scmd = SC_PUSH; ntop = nxt; end
          M_NIP:    scmd = SC_POP;
          M_LDI:    ntop = rd_data;
          M_STI:    begin scmd = SC_POP2; st_we = 1'b1; st_addr = nxt[AW-1:0]; end
          M_PUSHPC: begin scmd = SC_PUSH; ntop = {{(DW-AW){1'b0}}, pc_inc}; end
          default:  begin scmd = SC_POP; ntop = nxt; pc_nxt = top[AW-1:0]; end
        endcase
      end
      OP_IN:  begin scmd = SC_PUSH; ntop = io_rd; end
      OP_OUT: begin scmd = SC_POP; ntop = nxt; io_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  // R5
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opc == OP_JMP |=> pc_q == $past(tgt));

  // R13
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OP_NOP || opc > OP_OUT || opc == OP_PUSHI) |=> pc_q == $past(pc_q) + AW'(1));

  // R6
  popc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OP_MISC && fld[2:0] == M_POPPC) |=> pc_q == $past(top[AW-1:0]));
endmodule

// File: tb/tos_cpu_tb.sv
`timescale 1ns/1ps
module tos_cpu_tb_top;
  localparam int DW = 18;
  localparam int AW = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              prog_we;
  logic [AW-1:0]     prog_addr;
  logic [DW-1:0]     prog_data;
  logic [4*DW-1:0]   ext_in;
  logic [4*DW-1:0]   ext_out;
  logic [3:0]        ext_out_stb;

  int nchk = 0;
  int nbad = 0;
  int wa;

  int          q_port [$];
  logic [17:0] q_val  [$];
  string       q_req  [$];

  always #2.5 clk = ~clk;

  tos_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .ext_in(ext_in), .ext_out(ext_out),
    .ext_out_stb(ext_out_stb)
  );

  function automatic logic [15:0] enc(input int op, input int f);
    return {op[3:0], f[11:0]};
  endfunction

  task automatic put(input int a, input logic [17:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a[AW-1:0]; prog_data = d;
  endtask

  task automatic w(input logic [15:0] v);
    put(wa, {2'b00, v});
    wa++;
  endtask

  task automatic expect_out(input int port, input logic [17:0] v, input string req);
    q_port.push_back(port); q_val.push_back(v); q_req.push_back(req);
  endtask

  task automatic chk(input string req, input logic ok, input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic halt();
    w(enc(4, wa));
  endtask

  task automatic run(input int ncyc);
    @(negedge clk); prog_we = 1'b0;
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
    while (q_port.size() > 0) begin
      nchk++; nbad++;
      $display("FAIL %s missing output port=%0d act=none exp=%h",
               q_req[0], q_port[0], q_val[0]);
      void'(q_port.pop_front()); void'(q_val.pop_front()); void'(q_req.pop_front());
    end
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    wa = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (ext_out_stb[k]) begin
          if (q_port.size() == 0) begin
            nchk++; nbad++;
            $display("FAIL R12 unexpected strobe port=%0d act=%h exp=none", k, ext_out[k*DW +: DW]);
          end else begin
            int p; logic [17:0] v; string r;
            p = q_port.pop_front(); v = q_val.pop_front(); r = q_req.pop_front();
            nchk++;
            if (p != k || ext_out[k*DW +: DW] != v) begin
              nbad++;
              $display("FAIL %s port act=%0d exp=%0d value act=%h exp=%h",
                       r, k, p, ext_out[k*DW +: DW], v);
            end
          end
        end
      end
    end
  end

  function automatic logic [17:0] ref_bin(input int op, input int a, input int b);
    logic signed [17:0] x, y;
    longint p, f;
    logic [4:0] s;
    x = a[17:0]; y = b[17:0]; s = y[4:0];
    p = longint'(x) * longint'(y);
    f = p >>> 8;
    case (op)
      0:  return 18'(x + y);
      1:  return 18'(x - y);
      2:  return p[17:0];
      3:  return f[17:0];
      4:  return 18'(x << s);
      5:  return $unsigned(x) >> s;
      6:  return 18'(x >>> s);
      7:  return x & y;
      8:  return x | y;
      9:  return x ^ y;
      10: return (x != 0 && y != 0) ? 18'd1 : 18'd0;
      11: return (x != 0 || y != 0) ? 18'd1 : 18'd0;
      12: return (x == y) ? 18'd1 : 18'd0;
      13: return (x != y) ? 18'd1 : 18'd0;
      14: return (x >= y) ? 18'd1 : 18'd0;
      15: return (x <= y) ? 18'd1 : 18'd0;
      16: return (x > y)  ? 18'd1 : 18'd0;
      default: return (x < y) ? 18'd1 : 18'd0;
    endcase
  endfunction

  function automatic logic [17:0] ref_un(input int op, input int a);
    logic [17:0] x;
    x = a[17:0];
    case (op)
      18: return 18'(-x);
      19: return ~x;
      default: return (x == 0) ? 18'd1 : 18'd0;
    endcase
  endfunction

  function automatic string alu_req(input int op);
    if (op < 4)  return "R7";
    if (op < 12) return "R8";
    if (op < 18) return "R9";
    return "R10";
  endfunction

  initial begin
    #500000;
    nchk++; nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int av [4];
    int bv [4];
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0; ext_in = '0; wa = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", ext_out == '0 && ext_out_stb == '0, ext_out[17:0], 18'd0);

    // R2, R13: immediates and no-op classes
    w(enc(1, 5));     w(enc(10, 0)); expect_out(0, 18'd5, "R2");
    w(enc(1, -3));    w(enc(10, 1)); expect_out(1, 18'h3FFFD, "R2");
    w(16'hB123); w(16'h0000); w(16'hF7FF);
    w(enc(1, 2047));  w(enc(10, 2)); expect_out(2, 18'd2047, "R13");
    w(enc(1, -2048)); w(enc(10, 3)); expect_out(3, 18'h3F800, "R2");
    halt();
    run(40);
    // R1: reset clears held outputs
    chk("R1 reset clears", ext_out == '0 && ext_out_stb == '0, ext_out[17:0], 18'd0);

    // R3, R4: direct and indirect memory
    put(300, 18'h2ABCD);
    w(enc(2, 300)); w(enc(10, 0)); expect_out(0, 18'h2ABCD, "R3");
    w(enc(1, 9)); w(enc(1, 77)); w(enc(3, 301)); w(enc(10, 0)); expect_out(0, 18'd9, "R3");
    w(enc(2, 301)); w(enc(10, 0)); expect_out(0, 18'd77, "R3");
    w(enc(1, 4)); w(enc(1, 302)); w(enc(1, 55)); w(enc(8, 5)); w(enc(10, 0));
    expect_out(0, 18'd4, "R4");
    w(enc(1, 302)); w(enc(8, 4)); w(enc(10, 0)); expect_out(0, 18'd55, "R4");
    w(enc(1, 300)); w(enc(8, 4)); w(enc(10, 1)); expect_out(1, 18'h2ABCD, "R4");
    halt();
    run(60);

    // R5: jumps
    w(enc(1, 42)); w(enc(1, 0)); w(enc(5, 5)); w(enc(1, 77)); w(enc(10, 0));
    w(enc(1, 1)); w(enc(5, 9)); w(enc(1, 11)); w(enc(10, 0));
    expect_out(0, 18'd11, "R5");
    w(enc(1, 2)); w(enc(6, 13)); w(enc(1, 66)); w(enc(10, 0));
    w(enc(1, 0)); w(enc(6, 16)); w(enc(10, 1));
    expect_out(1, 18'd42, "R5");
    w(enc(4, 19)); w(enc(1, 5)); w(enc(10, 0));
    halt();
    run(60);

    // R6: call and return through the stack
    w(enc(1, 8)); w(enc(8, 6)); w(enc(1, 3)); w(enc(7, 0)); w(enc(4, 10));
    w(enc(10, 1)); w(enc(8, 6)); w(enc(10, 2)); halt();
    wa = 10;
    w(enc(1, 21)); w(enc(10, 0)); w(enc(8, 7));
    expect_out(0, 18'd21, "R6");
    expect_out(1, 18'd8, "R6");
    expect_out(2, 18'd7, "R6");
    run(40);

    // R11: stack shuffles and full depth
    w(enc(1, 1)); w(enc(1, 2)); w(enc(8, 2));
    w(enc(10, 0)); w(enc(10, 0)); w(enc(10, 0));
    expect_out(0, 18'd1, "R11 over"); expect_out(0, 18'd2, "R11 over"); expect_out(0, 18'd1, "R11 over");
    w(enc(1, 5)); w(enc(8, 0)); w(enc(7, 0)); w(enc(10, 0)); expect_out(0, 18'd10, "R11 dup");
    w(enc(1, 7)); w(enc(1, 8)); w(enc(8, 3)); w(enc(10, 0)); expect_out(0, 18'd8, "R11 nip");
    w(enc(1, 3)); w(enc(1, 4)); w(enc(8, 1)); w(enc(10, 0)); expect_out(0, 18'd3, "R11 drop");
    for (int i = 1; i <= 16; i++) w(enc(1, i));
    for (int i = 0; i < 15; i++) w(enc(7, 0));
    w(enc(10, 3)); expect_out(3, 18'd136, "R11 depth");
    halt();
    run(90);

    // R12: ports
    ext_in = {18'd12345, 18'h3FFFF, 18'd0, 18'h15555};
    w(enc(9, 0)); w(enc(10, 0)); expect_out(0, 18'h15555, "R12");
    w(enc(9, 3)); w(enc(10, 1)); expect_out(1, 18'd12345, "R12");
    w(enc(9, 2)); w(enc(10, 2)); expect_out(2, 18'h3FFFF, "R12");
    w(enc(1, 13)); w(enc(10, 5)); w(enc(9, 5)); w(enc(10, 3)); expect_out(3, 18'd13, "R12");
    w(enc(9, 6)); w(enc(10, 0)); expect_out(0, 18'd0, "R12");
    w(enc(1, 9)); w(enc(10, 7)); w(enc(9, 7)); w(enc(9, 5)); w(enc(7, 0)); w(enc(10, 2));
    expect_out(2, 18'd22, "R12");
    halt();
    run(60);

    // R7..R10: ALU sweep
    av = '{100, -20, 5, 0};
    bv = '{7, 3, 5, 9};
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 18; op++) begin
        w(enc(1, av[p])); w(enc(1, bv[p])); w(enc(7, op)); w(enc(10, 0));
        expect_out(0, ref_bin(op, av[p], bv[p]), alu_req(op));
      end
    end
    for (int p = 0; p < 4; p++) begin
      for (int op = 18; op < 21; op++) begin
        w(enc(1, av[p])); w(enc(7, op)); w(enc(10, 1));
        expect_out(1, ref_un(op, av[p]), alu_req(op));
      end
    end
    halt();
    run(380);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule